// File: doc/BRIEF.md
# Receive Port with Watermark-Gated Availability

This block is the receive side of a cell/packet PHY port. It sits between an ingress FIFO, which holds data words each tagged with an end-of-unit marker, and a bus master that selects the port with an active-low enable. The block drives an available flag that tells the master a transfer may start. The flag rises when the FIFO holds at least a programmable low watermark of words, or when any end marker sits in the FIFO. While the port is selected, it returns one word per clock. That word is either real FIFO data, marked valid, or a fixed filler word that the master must discard.

Two framing modes are supported. In cell mode a transfer, once begun, runs until a fixed 53-byte cell has been sent, packed into bus-width words. It ends earlier only at an end marker or when the FIFO runs dry. In packet mode the transfer runs until an end marker is read or the FIFO is drained. In both modes the available flag is held high for the whole transfer, even when occupancy falls below the watermark. The first and last FIFO words of a transfer carry start and end strobes. A FIFO that runs dry ends the transfer quietly, with no error indication.

Top module: `rxport_top`

## Requirements
- R1: After synchronous reset, rx_avail, rx_valid, rx_sop, rx_eop and fifo_pop are all 0.
- R2: While no transfer is in progress, rx_avail is set at a rising clock edge only if, just before that edge, fifo_level >= low_wm or fifo_eom_any = 1. Otherwise it is 0 after that edge.
- R3: While rx_enb_n = 1, fifo_pop stays 0, and after the edge rx_valid = 0. A paused transfer keeps rx_avail = 1.
- R4: When rx_enb_n = 0 and no word is popped (port not available), the next output has rx_data = FILL_WORD (default 16'hDEAD) and rx_valid = 0.
- R5: When rx_enb_n = 0 and a transfer is active with a non-empty FIFO, fifo_pop = 1 in that cycle. After the edge, rx_data equals the popped head word and rx_valid = 1, and words come out in FIFO order.
- R6: rx_sop = 1 with the first word of a transfer. rx_eop = 1 with the last word, and a word whose end marker (fifo_rd_eom = 1) is set is always the last, even if more data follows it.
- R7: In cell mode (mode_pkt = 0) a transfer ends with rx_eop after exactly CELL_WORDS words (27 for a 16-bit bus), unless an end marker or an empty FIFO ends it earlier.
- R8: A transfer whose FIFO runs dry ends with rx_eop on the last word. No pop is issued on an empty FIFO, and later selected cycles yield filler.
- R9: In packet mode (mode_pkt = 1), rx_avail stays 1 during a transfer after occupancy falls below low_wm, until the transfer ends.
- R10: In cell mode, a started cell keeps rx_avail = 1 after occupancy falls below low_wm, and it resumes after the master pauses it.
- R11: At the edge that sends the last word of a transfer, rx_avail falls to 0. It is then re-evaluated per R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, all state on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_pkt | input | 1 | 1 = packet mode, 0 = cell mode |
| low_wm | input | LEVEL_W | Low watermark in words |
| rx_enb_n | input | 1 | Active-low port select from master |
| fifo_level | input | LEVEL_W | FIFO occupancy in words |
| fifo_eom_any | input | 1 | Some FIFO entry carries an end marker |
| fifo_rd_data | input | DATA_W | FIFO head word |
| fifo_rd_eom | input | 1 | End marker of the head word |
| fifo_pop | output | 1 | Remove head word at this edge |
| rx_avail | output | 1 | Cell/packet available flag |
| rx_data | output | DATA_W | Output word, FIFO data or filler |
| rx_valid | output | 1 | rx_data is FIFO data |
| rx_sop | output | 1 | First word of a transfer |
| rx_eop | output | 1 | Last word of a transfer |

## Verification
The assertions assume the FIFO reports coherently: fifo_level counts the stored words, fifo_eom_any agrees with the stored markers, and the head word and its marker are valid whenever fifo_level is nonzero. The assertions also assume that mode_pkt and low_wm change only between transfers. The bench meets these assumptions by modelling the FIFO as a queue and deriving every FIFO input from that queue after each pop or load. It changes mode and watermark only while the port is idle, and it never uses a zero watermark.

// File: rtl/rxport_pkg.sv
package rxport_pkg;

    localparam int ATM_CELL_BYTES = 53;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xfer_state_e;

    // number of bus words that carry one fixed-size cell
    function automatic int cell_word_count(input int data_w);
        int bytes_per_word;
        bytes_per_word = data_w / 8;
        if (bytes_per_word < 1) bytes_per_word = 1;
        return (ATM_CELL_BYTES + bytes_per_word - 1) / bytes_per_word;
    endfunction

endpackage

// File: rtl/rxport_ready.sv
module rxport_ready #(
    parameter int LEVEL_W = 8
) (
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic [LEVEL_W-1:0] low_wm,
    input  logic               fifo_eom_any,
    output logic               ready
);
    always_comb begin
        ready = (fifo_level >= low_wm) || fifo_eom_any;
    end
endmodule

// File: rtl/rxport_ctrl.sv
module rxport_ctrl
    import rxport_pkg::*;
#(
    parameter int LEVEL_W    = 8,
    parameter int CELL_WORDS = 27
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_pkt,
    input  logic               rx_enb_n,
    input  logic               ready,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               fifo_rd_eom,
    output logic               pop,
    output logic               first,
    output logic               last,
    output logic               avail,
    output logic               in_xfer
);
    localparam int CNT_W = $clog2(CELL_WORDS + 1);

    xfer_state_e       state_q, state_d;
    logic [CNT_W-1:0]  wcnt_q;
    logic              avail_q;
    logic              active;
    logic              cell_done;

    always_comb begin
        active    = (state_q == ST_XFER) || avail_q;
        pop       = !rx_enb_n && active && (fifo_level != '0);
        cell_done = !mode_pkt && (wcnt_q == CNT_W'(CELL_WORDS - 1));
        last      = pop && (fifo_rd_eom || (fifo_level == LEVEL_W'(1)) || cell_done);
        first     = pop && (state_q == ST_IDLE);
        if (last)     state_d = ST_IDLE;
        else if (pop) state_d = ST_XFER;
        else          state_d = state_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
            avail_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (last)     wcnt_q <= '0;
            else if (pop) wcnt_q <= wcnt_q + 1'b1;
            if (last)                     avail_q <= 1'b0;
            else if (state_d == ST_XFER)  avail_q <= 1'b1;
            else                          avail_q <= ready;
        end
    end

    assign avail   = avail_q;
    assign in_xfer = (state_q == ST_XFER);

    // R7: the word count within a cell never reaches the cell length
    a_r7_cell_count_bound: assert property (@(posedge clk) disable iff (rst)
        !mode_pkt |-> (wcnt_q < CNT_W'(CELL_WORDS)));

    // R10: a cell in progress keeps the available flag high
    a_r10_cell_holds_avail: assert property (@(posedge clk) disable iff (rst)
        (in_xfer && !mode_pkt) |-> avail_q);

    // R9: a packet in progress keeps the available flag high
    a_r9_pkt_holds_avail: assert property (@(posedge clk) disable iff (rst)
        (in_xfer && mode_pkt) |-> avail_q);

    // R11: the last word of a transfer drops the flag
    a_r11_end_drops_avail: assert property (@(posedge clk) disable iff (rst)
        last |=> !avail_q);
endmodule

// File: rtl/rxport_out.sv
module rxport_out #(
    parameter int          DATA_W    = 16,
    parameter logic [DATA_W-1:0] FILL_WORD = 16'hDEAD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_enb_n,
    input  logic              pop,
    input  logic              first,
    input  logic              last,
    input  logic [DATA_W-1:0] fifo_rd_data,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_sop,
    output logic              rx_eop
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
            rx_sop   <= 1'b0;
            rx_eop   <= 1'b0;
        end else if (pop) begin
            rx_data  <= fifo_rd_data;
            rx_valid <= 1'b1;
            rx_sop   <= first;
            rx_eop   <= last;
        end else begin
            if (!rx_enb_n) rx_data <= FILL_WORD;
            rx_valid <= 1'b0;
            rx_sop   <= 1'b0;
            rx_eop   <= 1'b0;
        end
    end

    // R4: a selected cycle without a pop yields filler
    a_r4_filler_word: assert property (@(posedge clk) disable iff (rst)
        (!rx_enb_n && !pop) |=> (!rx_valid && rx_data == FILL_WORD));

    // R6: strobes only accompany valid words
    a_r6_strobes_need_valid: assert property (@(posedge clk) disable iff (rst)
        (rx_sop || rx_eop) |-> rx_valid);
endmodule

// File: rtl/rxport_top.sv
module rxport_top
    import rxport_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter int                LEVEL_W   = 8,
    parameter logic [DATA_W-1:0] FILL_WORD = 16'hDEAD
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_pkt,
    input  logic [LEVEL_W-1:0] low_wm,
    input  logic               rx_enb_n,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               fifo_eom_any,
    input  logic [DATA_W-1:0]  fifo_rd_data,
    input  logic               fifo_rd_eom,
    output logic               fifo_pop,
    output logic               rx_avail,
    output logic [DATA_W-1:0]  rx_data,
    output logic               rx_valid,
    output logic               rx_sop,
    output logic               rx_eop
);
    localparam int CELL_WORDS = cell_word_count(DATA_W);

    logic ready;
    logic first, last, in_xfer;

    rxport_ready #(.LEVEL_W(LEVEL_W)) u_ready (
        .fifo_level   (fifo_level),
        .low_wm       (low_wm),
        .fifo_eom_any (fifo_eom_any),
        .ready        (ready)
    );

    rxport_ctrl #(.LEVEL_W(LEVEL_W), .CELL_WORDS(CELL_WORDS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode_pkt    (mode_pkt),
        .rx_enb_n    (rx_enb_n),
        .ready       (ready),
        .fifo_level  (fifo_level),
        .fifo_rd_eom (fifo_rd_eom),
        .pop         (fifo_pop),
        .first       (first),
        .last        (last),
        .avail       (rx_avail),
        .in_xfer     (in_xfer)
    );

    rxport_out #(.DATA_W(DATA_W), .FILL_WORD(FILL_WORD)) u_out (
        .clk          (clk),
        .rst          (rst),
        .rx_enb_n     (rx_enb_n),
        .pop          (fifo_pop),
        .first        (first),
        .last         (last),
        .fifo_rd_data (fifo_rd_data),
        .rx_data      (rx_data),
        .rx_valid     (rx_valid),
        .rx_sop       (rx_sop),
        .rx_eop       (rx_eop)
    );

    // R8: never pop an empty FIFO
    a_r8_no_empty_pop: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> (fifo_level != '0));

    // R3: deselected port never pops
    a_r3_idle_when_deselected: assert property (@(posedge clk) disable iff (rst)
        rx_enb_n |-> !fifo_pop);

    // R5: every pop yields one valid word on the next cycle
    a_r5_pop_gives_valid: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> rx_valid);

    // R2: the flag rises only with enough data or an end marker
    a_r2_rise_needs_ready: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_avail) |-> $past((fifo_level >= low_wm) || fifo_eom_any || fifo_pop));
endmodule

// File: tb/test_rxport_top.sv
module test_rxport_top;
    localparam int DATA_W  = 16;
    localparam int LEVEL_W = 8;
    localparam int CELL    = (53 + 1) / 2;
    localparam logic [DATA_W-1:0] FILL = 16'hDEAD;

    typedef struct packed { logic eom; logic [DATA_W-1:0] d; } ent_t;
    typedef struct packed { logic [DATA_W-1:0] d; logic sop; logic eop; } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_pkt = 1'b1;
    logic [LEVEL_W-1:0] low_wm = 8'd16;
    logic rx_enb_n = 1'b1;
    logic [LEVEL_W-1:0] fifo_level = '0;
    logic fifo_eom_any = 1'b0;
    logic [DATA_W-1:0] fifo_rd_data = '0;
    logic fifo_rd_eom = 1'b0;
    logic fifo_pop, rx_avail, rx_valid, rx_sop, rx_eop;
    logic [DATA_W-1:0] rx_data;

    int checks = 0;
    int errors = 0;
    ent_t fq[$];
    exp_t xq[$];
    logic tb_xfer = 1'b0;
    int   tb_wcnt = 0;
    logic popped;
    logic [DATA_W-1:0] next_d = 16'h0100;

    rxport_top #(.DATA_W(DATA_W), .LEVEL_W(LEVEL_W), .FILL_WORD(FILL)) i_rxport_top (
        .clk(clk), .rst(rst), .mode_pkt(mode_pkt), .low_wm(low_wm),
        .rx_enb_n(rx_enb_n), .fifo_level(fifo_level), .fifo_eom_any(fifo_eom_any),
        .fifo_rd_data(fifo_rd_data), .fifo_rd_eom(fifo_rd_eom), .fifo_pop(fifo_pop),
        .rx_avail(rx_avail), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_sop(rx_sop), .rx_eop(rx_eop)
    );

    always #10 clk = ~clk;

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic refresh();
        fifo_level   = LEVEL_W'(fq.size());
        fifo_eom_any = 1'b0;
        foreach (fq[i]) if (fq[i].eom) fifo_eom_any = 1'b1;
        fifo_rd_data = (fq.size() != 0) ? fq[0].d : '0;
        fifo_rd_eom  = (fq.size() != 0) ? fq[0].eom : 1'b0;
    endtask

    task automatic load(input int n, input logic eom_last);
        for (int i = 0; i < n; i++) begin
            fq.push_back('{eom: (eom_last && i == n - 1), d: next_d});
            next_d = next_d + 1'b1;
        end
        refresh();
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic enb_n);
        exp_t e;
        rx_enb_n = enb_n;
        popped = 1'b0;
        #9;
        if (fifo_pop) begin
            popped = 1'b1;
            e.d   = fq[0].d;
            e.sop = !tb_xfer;
            e.eop = fq[0].eom || fq.size() == 1 || (!mode_pkt && tb_wcnt == CELL - 1);
            xq.push_back(e);
            if (e.eop) begin tb_xfer = 1'b0; tb_wcnt = 0; end
            else begin tb_xfer = 1'b1; tb_wcnt++; end
        end
        @(posedge clk);
        @(negedge clk);
        if (popped) begin
            void'(fq.pop_front());
            refresh();
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (xq.size() == 0) begin
                check(1'b0, "R5 unexpected word", int'(rx_data), 0);
            end else begin
                exp_t e;
                e = xq.pop_front();
                check(rx_data == e.d, "R5 data order", int'(rx_data), int'(e.d));
                check(rx_sop == e.sop, "R6 sop", int'(rx_sop), int'(e.sop));
                check(rx_eop == e.eop, "R6/R7/R8 eop", int'(rx_eop), int'(e.eop));
            end
        end
    end

    initial begin
        #(200000 * 20);
        check(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!rx_avail && !rx_valid && !rx_sop && !rx_eop && !fifo_pop, "R1 reset",
              {rx_avail, rx_valid, rx_sop, rx_eop, fifo_pop}, 0);

        // packet mode, few words, high watermark: not available
        load(3, 1'b0);
        step(1'b1);
        step(1'b1);
        check(!rx_avail, "R2 below watermark", rx_avail, 0);
        step(1'b0);
        check(!popped, "R4 no pop when unavailable", popped, 0);
        check(rx_data == FILL && !rx_valid, "R4 filler", int'(rx_data), int'(FILL));

        // end marker present, more words behind it
        load(4, 1'b1);
        load(2, 1'b0);
        step(1'b1);
        check(rx_avail, "R2 end marker sets avail", rx_avail, 1);
        step(1'b1);
        check(!popped && !rx_valid && rx_avail, "R3 deselected idle", {popped, rx_valid, rx_avail}, 1);
        for (int i = 0; i < 7; i++) step(1'b0);
        check(!rx_avail, "R11 avail drops at end", rx_avail, 1'b0);
        check(fq.size() == 2, "R6 stops at end marker", fq.size(), 2);
        step(1'b0);
        check(!popped && !rx_avail, "R11 re-evaluated low", {popped, rx_avail}, 0);

        // packet without marker, watermark 4: drains past watermark
        low_wm = 8'd4;
        load(4, 1'b0);
        step(1'b1);
        check(rx_avail, "R2 level reaches watermark", rx_avail, 1);
        for (int i = 0; i < 3; i++) step(1'b0);
        check(rx_avail && fifo_level < low_wm, "R9 pkt holds avail", rx_avail, 1);
        for (int i = 0; i < 3; i++) step(1'b0);
        check(fq.size() == 0 && !rx_avail, "R8 drained", fq.size(), 0);
        step(1'b0);
        check(!popped && !rx_valid && rx_data == FILL, "R8 no pop on empty", int'(rx_data), int'(FILL));

        // cell mode
        mode_pkt = 1'b0;
        low_wm = 8'(CELL);
        load(30, 1'b0);
        step(1'b1);
        check(rx_avail, "R2 cell mode ready", rx_avail, 1);
        for (int i = 0; i < 5; i++) step(1'b0);
        check(rx_avail && fifo_level < low_wm, "R10 cell holds avail", rx_avail, 1);
        for (int i = 0; i < CELL - 5; i++) step(1'b0);
        check(fq.size() == 3, "R7 cell length", fq.size(), 3);
        check(!rx_avail, "R11 avail drops after cell", rx_avail, 0);
        step(1'b0);
        check(!popped && rx_data == FILL && !rx_valid, "R4 filler after cell", int'(rx_data), int'(FILL));

        // cell with pause in the middle
        load(CELL - 3, 1'b0);
        step(1'b1);
        check(rx_avail, "R2 second cell ready", rx_avail, 1);
        for (int i = 0; i < 10; i++) step(1'b0);
        for (int i = 0; i < 3; i++) step(1'b1);
        check(!popped && rx_avail && !rx_valid, "R10 paused cell held", {popped, rx_avail, rx_valid}, 3'b010);
        for (int i = 0; i < CELL - 10; i++) step(1'b0);
        check(fq.size() == 0 && !rx_avail, "R7 second cell done", fq.size(), 0);
        step(1'b1);
        check(xq.size() == 0, "R5 all words delivered", xq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule